// File: doc/BRIEF.md
# Serial Transmitter with Coded Rate Generator

This block turns bytes into asynchronous serial frames on a single output line. A byte written into a one-entry holding register is moved into the frame engine at the next rate tick. The engine sends a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. Each bit lasts sixteen ticks of a shared 16x rate clock.

The 16x tick comes from a divider on the reference clock. A 4-bit rate code picks the divider from a small table of standard rates. The tick is also brought out so that a companion receiver can use it. The format input sets the word length, the stop length and the rate. Separate inputs select parity and request a line break. A transmit-empty flag tells the host when the next byte may be written. Because the flag rises while the current frame is still on the line, frames can follow each other with no idle gap.

Top module: `uart_tx_coded`

## Requirements
- R1: The 16x tick period in reference cycles is round(REF_HZ / (16 x baud)), at least 1. With fmt_i[4]=1 the baud comes from the rate code fmt_i[3:0]: 6 gives 300, 7 gives 600, 8 gives 1200, 10 gives 2400, 11 gives 3600, 12 gives 4800 and 14 gives 9600.
- R2: Any other rate code, or fmt_i[4]=0, gives the 9600 baud period.
- R3: A frame starts with one low bit. Data bits follow, least significant first, and each bit lasts 16 ticks. The data length is set by fmt_i[6:5]: 00 gives 8 bits, 01 gives 7, 10 gives 6 and 11 gives 5.
- R4: With par_en_i=1 and par_fixed_i=0, one parity bit follows the data. It is odd parity over the sent data bits when par_sel_i=0 and even parity when par_sel_i=1.
- R5: With par_en_i=1 and par_fixed_i=1, the parity bit is a constant: 1 when par_sel_i=0 and 0 when par_sel_i=1.
- R6: The stop period is high. It lasts 16 ticks when fmt_i[7]=0 and 32 ticks when fmt_i[7]=1, except in the cases of R7 and R8.
- R7: With fmt_i[7]=1, a 5-bit word without parity gets a 24-tick stop period.
- R8: With fmt_i[7]=1, an 8-bit word with parity gets a 16-tick stop period.
- R9: While brk_i=1, txd_o is low.
- R10: tx_empty_o is 1 after reset and goes to 0 in the cycle after a write. It returns to 1 in the same cycle the start bit of that byte begins. A byte written during a frame starts right at the end of that frame's stop period.
- R11: Format and parity settings are sampled when a byte moves into the engine. Changes made during a frame do not affect that frame.
- R12: With no frame in progress and no break, txd_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Byte to transmit |
| fmt_i | input | 8 | [3:0] rate code, [4] internal rate, [6:5] length, [7] long stop |
| par_en_i | input | 1 | Parity bit enable |
| par_fixed_i | input | 1 | Constant parity bit mode |
| par_sel_i | input | 1 | Parity select (see R4, R5) |
| brk_i | input | 1 | Force line low |
| txd_o | output | 1 | Serial output |
| tx_empty_o | output | 1 | Holding register empty |
| tick16_o | output | 1 | 16x rate tick, one cycle wide |

## Verification
The tick period is measured for all 32 combinations of the rate code and the internal-rate bit. This separates the listed codes from the fallback ones and checks the divider arithmetic. Frames are decoded bit by bit at their centres for every word length, every parity mode (none, odd, even, constant one, constant zero) and both stop settings. This shows that the parity polarity, the bit order and the length decode each behave as specified. Back-to-back frame pairs expose the stop length as the distance between start edges, which isolates the 1.5-stop and shortened-stop rules. A separate pair changes the settings mid-frame to show they are sampled at transfer, and break is applied both while idle and during a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // baud rate for a 4-bit rate code; unlisted codes fall back to 9600
  function automatic int unsigned code_baud(input int unsigned code);
    case (code)
      6:       return 300;
      7:       return 600;
      8:       return 1200;
      10:      return 2400;
      11:      return 3600;
      12:      return 4800;
      default: return 9600;
    endcase
  endfunction

  // rounded reference cycles per 16x tick, never below one
  function automatic int unsigned tick_div(input int unsigned ref_hz,
                                           input int unsigned baud);
    int unsigned d;
    d = (ref_hz + 8 * baud) / (16 * baud);
    return (d == 0) ? 1 : d;
  endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_tx_pkg::*;
#(
  parameter int unsigned REF_HZ = 1843200,
  parameter int unsigned DIVW   = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] code_i,
  input  logic       int_i,
  output logic       tick_o
);

  localparam int unsigned NCODE   = 16;
  localparam int unsigned FALL_M1 = tick_div(REF_HZ, 9600) - 1;

  logic [DIVW-1:0] tab_m1 [NCODE];
  logic [DIVW-1:0] lim_m1;
  logic [DIVW-1:0] cnt_q, cnt_d;

  for (genvar g = 0; g < NCODE; g++) begin : g_tab
    assign tab_m1[g] = DIVW'(tick_div(REF_HZ, code_baud(g)) - 1);
  end

  assign lim_m1 = int_i ? tab_m1[code_i] : DIVW'(FALL_M1);
  assign tick_o = (cnt_q >= lim_m1);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (tick_o) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R1: a tick restarts the period count
  p_tick_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          take_i,
  output logic [DW-1:0] data_o,
  output logic          full_o
);

  logic          full_q, full_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    full_d = wr_i | (full_q & ~take_i);
    data_d = wr_i ? wdata_i : data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R10: the engine only takes a byte that is present
  p_take_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       full_i,
  input  logic [7:0] data_i,
  input  logic [1:0] len_i,
  input  logic       stop2_i,
  input  logic       pen_i,
  input  logic       pfix_i,
  input  logic       psel_i,
  output logic       take_o,
  output logic       line_o
);

  localparam int unsigned TW      = 5;
  localparam logic [TW-1:0] BIT_M1 = TW'(15);

  tx_state_e  state_q, state_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [2:0] bidx_q, bidx_d;
  logic [2:0] nbm1_q, nbm1_d;
  logic [7:0] sh_q, sh_d;
  logic       pen_q, pen_d;
  logic       pbit_q, pbit_d;
  logic [TW-1:0] stopm1_q, stopm1_d;
  logic       line_q, line_d;

  // settings captured at transfer
  logic [2:0]    nbm1_w;
  logic [7:0]    mask_w;
  logic          pbit_w;
  logic [TW-1:0] stopm1_w;
  logic          do_load;
  logic          bit_end;

  always_comb begin
    nbm1_w = 3'd7 - {1'b0, len_i};
    mask_w = 8'hFF >> len_i;
    pbit_w = pfix_i ? ~psel_i : ((^(data_i & mask_w)) ^ ~psel_i);
    if (!stop2_i)                  stopm1_w = TW'(15);
    else if (len_i == 2'b11 && !pen_i) stopm1_w = TW'(23);
    else if (len_i == 2'b00 && pen_i)  stopm1_w = TW'(15);
    else                           stopm1_w = TW'(31);
  end

  assign bit_end = (tcnt_q == BIT_M1);

  always_comb begin
    state_d  = state_q;
    tcnt_d   = tcnt_q;
    bidx_d   = bidx_q;
    nbm1_d   = nbm1_q;
    sh_d     = sh_q;
    pen_d    = pen_q;
    pbit_d   = pbit_q;
    stopm1_d = stopm1_q;
    line_d   = line_q;
    do_load  = 1'b0;
    if (tick_i) begin
      tcnt_d = tcnt_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          tcnt_d = '0;
          if (full_i) do_load = 1'b1;
        end
        ST_START: if (bit_end) begin
          state_d = ST_DATA;
          tcnt_d  = '0;
          bidx_d  = '0;
          line_d  = sh_q[0];
        end
        ST_DATA: if (bit_end) begin
          tcnt_d = '0;
          if (bidx_q == nbm1_q) begin
            state_d = pen_q ? ST_PAR : ST_STOP;
            line_d  = pen_q ? pbit_q : 1'b1;
          end else begin
            bidx_d = bidx_q + 1'b1;
            sh_d   = sh_q >> 1;
            line_d = sh_q[1];
          end
        end
        ST_PAR: if (bit_end) begin
          state_d = ST_STOP;
          tcnt_d  = '0;
          line_d  = 1'b1;
        end
        ST_STOP: if (tcnt_q == stopm1_q) begin
          tcnt_d  = '0;
          state_d = ST_IDLE;
          if (full_i) do_load = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
      if (do_load) begin
        state_d  = ST_START;
        tcnt_d   = '0;
        line_d   = 1'b0;
        sh_d     = data_i;
        nbm1_d   = nbm1_w;
        pen_d    = pen_i;
        pbit_d   = pbit_w;
        stopm1_d = stopm1_w;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tcnt_q   <= '0;
      bidx_q   <= '0;
      nbm1_q   <= 3'd7;
      sh_q     <= '0;
      pen_q    <= 1'b0;
      pbit_q   <= 1'b0;
      stopm1_q <= TW'(15);
      line_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      tcnt_q   <= tcnt_d;
      bidx_q   <= bidx_d;
      nbm1_q   <= nbm1_d;
      sh_q     <= sh_d;
      pen_q    <= pen_d;
      pbit_q   <= pbit_d;
      stopm1_q <= stopm1_d;
      line_q   <= line_d;
    end
  end

  assign take_o = do_load;
  assign line_o = line_q;

  // R3: start bit is low for its whole duration
  p_start_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) |-> !line_q);
  // R3: data index never passes the captured word length
  p_idx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (bidx_q <= nbm1_q));
  // R6: stop period drives the line high
  p_stop_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> line_q);
  // R12: idle line is high
  p_idle_high_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> line_q);
  // R3: non-stop bits never exceed 16 ticks
  p_bit_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_STOP) |-> (tcnt_q <= BIT_M1));

endmodule

// File: rtl/uart_tx_coded.sv
module uart_tx_coded
  import uart_tx_pkg::*;
#(
  parameter int unsigned REF_HZ = 1843200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] fmt_i,
  input  logic       par_en_i,
  input  logic       par_fixed_i,
  input  logic       par_sel_i,
  input  logic       brk_i,
  output logic       txd_o,
  output logic       tx_empty_o,
  output logic       tick16_o
);

  localparam int unsigned MAXDIV = tick_div(REF_HZ, 300);
  localparam int unsigned DIVW   = (MAXDIV < 2) ? 1 : $clog2(MAXDIV);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       tick;
  logic       take;
  logic       full;
  logic [7:0] hold_data;
  logic       line;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  uart_baud_gen #(.REF_HZ(REF_HZ), .DIVW(DIVW)) baud_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .code_i (fmt_i[3:0]),
    .int_i  (fmt_i[4]),
    .tick_o (tick)
  );

  uart_tx_hold #(.DW(8)) hold_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .take_i  (take),
    .data_o  (hold_data),
    .full_o  (full)
  );

  uart_tx_engine eng_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .full_i  (full),
    .data_i  (hold_data),
    .len_i   (fmt_i[6:5]),
    .stop2_i (fmt_i[7]),
    .pen_i   (par_en_i),
    .pfix_i  (par_fixed_i),
    .psel_i  (par_sel_i),
    .take_o  (take),
    .line_o  (line)
  );

  assign txd_o      = brk_i ? 1'b0 : line;
  assign tx_empty_o = ~full;
  assign tick16_o   = tick;

  // R10: a transfer without a new write leaves the register empty
  p_empty_after_take_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(take && !wr_i) |-> tx_empty_o);
  // R10: a write always fills the register
  p_full_after_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(wr_i) |-> !tx_empty_o);

endmodule

// File: tb/uart_tx_coded_tb_top.sv
module uart_tx_coded_tb_top;

  localparam int unsigned REF = 460800;

  logic       clk;
  logic       rst_n;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] fmt;
  logic       pen, pfix, psel, brk;
  logic       txd, empty, tick;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  uart_tx_coded #(.REF_HZ(REF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .fmt_i(fmt),
    .par_en_i(pen), .par_fixed_i(pfix), .par_sel_i(psel), .brk_i(brk),
    .txd_o(txd), .tx_empty_o(empty), .tick16_o(tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_baud(input int code);
    case (code)
      6: return 300;   7: return 600;   8: return 1200;  10: return 2400;
      11: return 3600; 12: return 4800; default: return 9600;
    endcase
  endfunction

  function automatic int exp_div(input int code, input bit internal);
    int b;
    int d;
    b = internal ? exp_baud(code) : 9600;
    d = (REF + 8 * b) / (16 * b);
    return (d < 1) ? 1 : d;
  endfunction

  localparam int BITC = 16 * ((REF + 8 * 9600) / (16 * 9600));

  function automatic bit exp_par(input logic [7:0] d, input int nb, input int pm);
    logic [7:0] m;
    bit x;
    m = 8'hFF >> (8 - nb);
    x = ^(d & m);
    case (pm)
      1: return ~x;
      2: return x;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_stop(input bit sb, input int nb, input bit pe);
    if (!sb) return 16;
    if (nb == 5 && !pe) return 24;
    if (nb == 8 && pe) return 16;
    return 32;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic apply_cfg(input int ln, input int pm, input bit sb);
    fmt  = {sb, 2'(ln), 1'b1, 4'b1110};
    pen  = (pm != 0);
    pfix = (pm >= 3);
    psel = (pm == 2 || pm == 4);
  endtask

  task automatic rx_frame(input logic [7:0] d, input int nb, input bit pe,
                          input bit pb, input string ptag, output int t0);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (BITC / 2) @(negedge clk);
    chk(txd == 1'b0, "R3 start bit", txd, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (BITC) @(negedge clk);
      chk(txd == d[i], "R3 data bit", txd, d[i]);
    end
    if (pe) begin
      repeat (BITC) @(negedge clk);
      chk(txd == pb, ptag, txd, pb);
    end
    repeat (BITC) @(negedge clk);
    chk(txd == 1'b1, "R6 stop level", txd, 1);
  endtask

  // two frames; B config applied once A has moved into the engine
  task automatic run_pair(input logic [7:0] a, input int ln_a, input int pm_a, input bit sb_a,
                          input logic [7:0] b, input int ln_b, input int pm_b, input bit sb_b,
                          input string gtag);
    int ta, tb;
    int nba, nbb, st;
    nba = 8 - ln_a;
    nbb = 8 - ln_b;
    st  = exp_stop(sb_a, nba, pm_a != 0);
    apply_cfg(ln_a, pm_a, sb_a);
    fork
      begin
        wdata = a; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        chk(empty == 1'b0, "R10 cleared by write", empty, 0);
        while (empty !== 1'b1) @(negedge clk);
        chk(txd == 1'b0, "R10 empty with start bit", txd, 0);
        apply_cfg(ln_b, pm_b, sb_b);
        wdata = b; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
      end
      begin
        rx_frame(a, nba, pm_a != 0, exp_par(a, nba, pm_a),
                 (pm_a >= 3) ? "R5 fixed parity" : "R4 parity", ta);
        rx_frame(b, nbb, pm_b != 0, exp_par(b, nbb, pm_b),
                 (pm_b >= 3) ? "R5 fixed parity" : "R4 parity", tb);
        chk((tb - ta) == (1 + nba + (pm_a != 0 ? 1 : 0)) * BITC + st * (BITC / 16),
            gtag, tb - ta, (1 + nba + (pm_a != 0 ? 1 : 0)) * BITC + st * (BITC / 16));
      end
    join
    repeat (3 * BITC) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; wdata = '0; brk = 1'b0;
    fmt = 8'h1E; pen = 1'b0; pfix = 1'b0; psel = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(empty == 1'b1, "R10 reset empty", empty, 1);
    chk(txd == 1'b1, "R12 reset idle high", txd, 1);

    // R1 / R2: tick period for every code with and without internal rate
    for (int k = 0; k < 32; k++) begin
      int n;
      int e;
      fmt = {3'b000, 5'(k)};
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        while (tick !== 1'b1) @(negedge clk);
      end
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (tick !== 1'b1);
      e = exp_div(k % 16, k >= 16);
      if (k >= 16 && exp_baud(k % 16) != 9600 || (k >= 16 && (k % 16) == 14))
        chk(n == e, "R1 tick period", n, e);
      else
        chk(n == e, "R2 fallback period", n, e);
      chk(txd == 1'b1, "R12 idle during rate sweep", txd, 1);
    end

    // R3..R8, R10: every length, parity mode and stop setting
    for (int ln = 0; ln < 4; ln++)
      for (int pm = 0; pm < 5; pm++)
        for (int sb = 0; sb < 2; sb++) begin
          logic [7:0] a;
          string gt;
          int nb;
          nb = 8 - ln;
          a = 8'(8'h5A ^ (ln * 50 + pm * 13 + sb * 7));
          if (sb == 1 && nb == 5 && pm == 0)      gt = "R7 stop 1.5";
          else if (sb == 1 && nb == 8 && pm != 0) gt = "R8 stop shortened";
          else                                    gt = "R6 stop length";
          run_pair(a, ln, pm, sb[0], ~a ^ 8'h33, ln, pm, sb[0], gt);
        end

    // R11: settings changed during frame A must not alter A
    run_pair(8'hC3, 0, 0, 1'b0, 8'h16, 3, 2, 1'b1, "R11 frame kept its settings");

    // R9: break while idle
    brk = 1'b1;
    for (int i = 0; i < 10; i++) begin
      repeat (7) @(negedge clk);
      chk(txd == 1'b0, "R9 break idle", txd, 0);
    end
    brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R12 idle after break", txd, 1);

    // R9: break during a frame of all ones
    apply_cfg(0, 0, 1'b0);
    wdata = 8'hFF; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    repeat (2 * BITC) @(negedge clk);
    brk = 1'b1;
    for (int i = 0; i < 20; i++) begin
      repeat (11) @(negedge clk);
      chk(txd == 1'b0, "R9 break in frame", txd, 0);
    end
    brk = 1'b0;
    repeat (12 * BITC) @(negedge clk);
    chk(txd == 1'b1, "R12 idle after frame", txd, 1);
    chk(empty == 1'b1, "R10 empty at end", empty, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule